// File: doc/BRIEF.md
# Bus-snooping Internet checksum peripheral

The block sits on a simple single-beat bus as a memory-mapped target and also watches every other beat on that bus. While its enable bit is set, the data word of each beat addressed elsewhere is added into a 32-bit register. That register holds two independent 16-bit ones'-complement sums: one over the upper half-words and one over the lower half-words. This lets DMA or programmed-I/O traffic be checksummed in the background, with no extra bus cycles.

The adder is a ring of short segments joined by carry registers, so each cycle has only a few bits of carry logic. Carries still in flight settle over a fixed number of idle cycles after the last accumulated beat, and a ready flag reports when they have. Software clears the register, enables summing, moves the data, disables summing and reads the result. The status word also carries the finished 16-bit checksum: the two halves are folded with end-around carry and the result is inverted. To start from an initial value, write that value to any address outside the block while summing is enabled.

Top module: `csum_snoop`

## Requirements
- R1: A read beat to offset 0x4 (the sum location) returns the 32-bit partial register {upper sum, lower sum} on rd_data_o from the clock edge that captures the beat, and it does not alter the register.
- R2: A write beat of any data to offset 0x4 clears both sums and every carry in flight, and leaves the ready flag set.
- R3: Offset 0x0 is the control word. Bit 0 is the enable bit (1 accumulates, 0 ignores). It is written from bit 0 of the data and read back in bit 0 with all other bits zero.
- R4: While enabled, every valid beat to an address outside the block, whether read or write, is accumulated. Data bits 31:16 go into the upper sum and bits 15:0 into the lower sum, each with ones'-complement (end-around carry) addition.
- R5: While disabled, beats to other addresses leave the partial register unchanged.
- R6: Beats to the block's own four word addresses (BASE_ADDR plus 0x0, 0x4, 0x8, 0xC) are never accumulated.
- R7: Offset 0x8 is the status word. Bit 16 is the ready flag and bits 15:0 hold the inverted end-around fold of the two sums. The flag reads 0 while fewer than 5 idle clocks have passed since the last accumulated beat. Once at least 5 have passed, it reads 1 and the checksum is final.
- R8: Clearing, enabling and then writing a value V to any outside address preloads the sums with V.
- R9: After reset, the enable bit is 0, the partial register is 0, ready is 1 and rd_data_o is 0.
- R10: Beats on consecutive cycles are each accumulated, including data that forces carries through every segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | A bus beat is present this cycle |
| bus_write_i | input | 1 | Beat direction: 1 write, 0 read |
| bus_addr_i | input | ADDR_W | Byte address of the beat |
| bus_data_i | input | 32 | Data word of the beat: write data, or the read data returned by whichever target answers |
| rd_data_o | output | 32 | Read data for beats addressed to this block, registered |

## Verification
The accumulator is driven with four kinds of pattern:
- A short mix of read and write beats with ordinary values. This exposes errors in half-word placement and in the end-around fold.
- Long back-to-back runs of generated words together with all-ones-heavy words. Only these push carries around the whole ring, so they catch wrong carry routing or early settling.
- Beats while disabled and beats to the block's own addresses. These must leave the register untouched, which separates the enable gate from the address filter.
- A preload, and a clear issued in the middle of draining. These show that a dummy write seeds the sum and that a clear also discards carries still in flight.

Reading the status word on the 5th and 6th edges after the last accumulated beat pins the ready flag to the exact cycle.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    OFF_CTRL = 2'd0,
    OFF_SUM  = 2'd1,
    OFF_STAT = 2'd2,
    OFF_RSVD = 2'd3
  } reg_off_e;
endpackage

// File: rtl/csum_lane.sv
// One 16-bit ones'-complement sum built as a ring of SEG_W-bit adders.
// SEG_W must divide LANE_W and be at least 4 for the drain bound to hold.
module csum_lane #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned SEG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [LANE_W-1:0] data_i,
  output logic [LANE_W-1:0] sum_o,
  output logic [LANE_W/SEG_W-1:0] cy_o
);
  localparam int unsigned NSEG = LANE_W / SEG_W;

  logic [SEG_W-1:0] seg_q [NSEG];
  logic [NSEG-1:0]  cy_q;
  logic [SEG_W:0]   nxt_w [NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int unsigned PREV = (k == 0) ? NSEG - 1 : k - 1;
    logic [SEG_W-1:0] opnd;
    assign opnd     = add_i ? data_i[k*SEG_W +: SEG_W] : '0;
    // carry of the previous segment closes the ring (end-around carry)
    assign nxt_w[k] = {1'b0, seg_q[k]} + {1'b0, opnd} + {{SEG_W{1'b0}}, cy_q[PREV]};
    assign sum_o[k*SEG_W +: SEG_W] = seg_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NSEG; k++) seg_q[k] <= '0;
      cy_q <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < NSEG; k++) seg_q[k] <= '0;
      cy_q <= '0;
    end else begin
      for (int k = 0; k < NSEG; k++) begin
        seg_q[k] <= nxt_w[k][SEG_W-1:0];
        cy_q[k]  <= nxt_w[k][SEG_W];
      end
    end
  end

  assign cy_o = cy_q;

  // a segment that just passed a carry on an idle cycle holds zero
  assert_pass_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!add_i && !clr_i) && cy_q[0] && !$past(cy_q[0])) |-> (sum_o[SEG_W-1:0] == '0));
endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
  parameter int unsigned SEG_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         add_i,
  input  logic [csum_pkg::WORD_W-1:0]  data_i,
  output logic [csum_pkg::WORD_W-1:0]  sum_o,
  output logic [2*(csum_pkg::HALF_W/SEG_W)-1:0] cy_o
);
  localparam int unsigned HW   = csum_pkg::HALF_W;
  localparam int unsigned NSEG = HW / SEG_W;

  for (genvar h = 0; h < 2; h++) begin : g_half
    csum_lane #(.LANE_W(HW), .SEG_W(SEG_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .add_i  (add_i),
      .data_i (data_i[h*HW +: HW]),
      .sum_o  (sum_o[h*HW +: HW]),
      .cy_o   (cy_o[h*NSEG +: NSEG])
    );
  end
endmodule

// File: rtl/csum_drain.sv
module csum_drain #(
  parameter int unsigned DRAIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic add_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(DRAIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (add_i)         cnt_q <= CW'(DRAIN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  assert_busy_after_add_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> !ready_o);
endmodule

// File: rtl/csum_regs.sv
module csum_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_valid_i,
  input  logic                        bus_write_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [csum_pkg::WORD_W-1:0] bus_data_i,
  input  logic [csum_pkg::WORD_W-1:0] sum_i,
  input  logic [csum_pkg::WORD_W-1:0] stat_i,
  output logic                        add_o,
  output logic                        clr_o,
  output logic [csum_pkg::WORD_W-1:0] rd_data_o
);
  import csum_pkg::*;

  logic     hit, en_q;
  reg_off_e off;
  logic [WORD_W-1:0] rd_q, rd_nxt;

  assign hit   = (bus_addr_i[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign off   = reg_off_e'(bus_addr_i[3:2]);
  assign add_o = bus_valid_i && !hit && en_q;
  assign clr_o = bus_valid_i && hit && bus_write_i && (off == OFF_SUM);

  always_comb begin
    unique case (off)
      OFF_CTRL: rd_nxt = {{(WORD_W-1){1'b0}}, en_q};
      OFF_SUM:  rd_nxt = sum_i;
      OFF_STAT: rd_nxt = stat_i;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      rd_q <= '0;
    end else if (bus_valid_i && hit) begin
      if (bus_write_i) begin
        if (off == OFF_CTRL) en_q <= bus_data_i[0];
      end else begin
        rd_q <= rd_nxt;
      end
    end
  end

  assign rd_data_o = rd_q;

  assert_read_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && hit && !bus_write_i && off == OFF_SUM) |=> (rd_data_o == $past(sum_i)));

  assert_own_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && hit) |=> $stable(en_q) || $past(bus_write_i && off == OFF_CTRL));
endmodule

// File: rtl/csum_snoop.sv
module csum_snoop #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100,
  parameter int unsigned SEG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_data_i,
  output logic [31:0]       rd_data_o
);
  import csum_pkg::*;

  localparam int unsigned NSEG  = HALF_W / SEG_W;
  localparam int unsigned DRAIN = NSEG + 1;

  logic              add, clr, ready;
  logic [WORD_W-1:0] sum, stat;
  logic [2*NSEG-1:0] cy;
  logic [HALF_W:0]   fsum;
  logic [HALF_W-1:0] fwrap;

  csum_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_data_i  (bus_data_i),
    .sum_i       (sum),
    .stat_i      (stat),
    .add_o       (add),
    .clr_o       (clr),
    .rd_data_o   (rd_data_o)
  );

  csum_acc #(.SEG_W(SEG_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .add_i  (add),
    .data_i (bus_data_i),
    .sum_o  (sum),
    .cy_o   (cy)
  );

  csum_drain #(.DRAIN(DRAIN)) u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .add_i   (add),
    .ready_o (ready)
  );

  // fold halves with end-around carry, then invert
  assign fsum  = {1'b0, sum[WORD_W-1:HALF_W]} + {1'b0, sum[HALF_W-1:0]};
  assign fwrap = fsum[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, fsum[HALF_W]};
  assign stat  = {{(WORD_W-HALF_W-1){1'b0}}, ready, ~fwrap};

  assert_settled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (cy == '0));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !add && !clr) |=> $stable(sum));

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (sum == '0) && ready);
endmodule

// File: tb/tb_csum_snoop.sv
`timescale 1ns/1ps
module tb_csum_snoop;
  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [15:0] A_CTRL = BASE + 16'h0;
  localparam logic [15:0] A_SUM  = BASE + 16'h4;
  localparam logic [15:0] A_STAT = BASE + 16'h8;
  localparam logic [15:0] A_RSVD = BASE + 16'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] data = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic        m_en = 1'b0;
  logic [15:0] m_lo = '0, m_hi = '0;

  always #4 clk = ~clk;

  csum_snoop #(.ADDR_W(16), .BASE_ADDR(BASE), .SEG_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_data_i(data), .rd_data_o(rdata)
  );

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  function automatic logic [31:0] exp_stat(input logic rdy);
    return {15'b0, rdy, ~oc_add(m_hi, m_lo)};
  endfunction

  function automatic bit own(input logic [15:0] a);
    return a[15:4] == BASE[15:4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic beat(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a; data = d;
    @(posedge clk);
    #1 valid = 1'b0;
    if (own(a)) begin
      if (w && a == A_CTRL) m_en = d[0];
      if (w && a == A_SUM) begin m_lo = '0; m_hi = '0; end
    end else if (m_en) begin
      m_lo = oc_add(m_lo, d[15:0]);
      m_hi = oc_add(m_hi, d[31:16]);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    beat(1'b0, a, 32'h0);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R9 rd_data after reset", rdata, 32'h0);
    rd(A_CTRL, v); check("R9 enable after reset", v, 32'h0);
    rd(A_SUM, v);  check("R9 partial after reset", v, 32'h0);
    rd(A_STAT, v); check("R9 status after reset", v, 32'h0001_FFFF);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    beat(1'b1, A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R3 enable set", v, 32'h1);
    beat(1'b1, A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check("R3 enable clear", v, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] v, v2;
    beat(1'b1, A_SUM, 32'h0);
    beat(1'b1, A_CTRL, 32'h1);
    beat(1'b1, 16'h2000, 32'h4500_0073);
    beat(1'b0, 16'h2004, 32'h0000_4000);
    beat(1'b1, 16'h2008, 32'h4011_0000);
    beat(1'b0, 16'h200C, 32'hC0A8_0001);
    beat(1'b1, 16'h2010, 32'hC0A8_00C7);
    beat(1'b1, A_CTRL, 32'h0);
    idle(6);
    rd(A_STAT, v); check("R4 checksum of mixed beats", v, exp_stat(1'b1));
    rd(A_SUM, v);  check("R1 partial register", v, {m_hi, m_lo});
    rd(A_SUM, v2); check("R1 read is non-destructive", v2, {m_hi, m_lo});
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    beat(1'b1, 16'h3000, 32'h1234_5678);
    beat(1'b0, 16'h3004, 32'hFFFF_0001);
    idle(6);
    rd(A_SUM, v); check("R5 disabled beats ignored", v, {m_hi, m_lo});
  endtask

  task automatic t_own;
    logic [31:0] v;
    beat(1'b1, A_CTRL, 32'h1);
    beat(1'b1, A_RSVD, 32'h5555_AAAA);
    beat(1'b1, A_STAT, 32'h0F0F_0F0F);
    beat(1'b1, A_CTRL, 32'h0000_0003);
    rd(A_CTRL, v);
    rd(A_STAT, v);
    rd(A_SUM, v); check("R6 own-address beats not summed", v, {m_hi, m_lo});
    beat(1'b1, A_CTRL, 32'h0);
  endtask

  task automatic t_burst;
    logic [31:0] v, x;
    x = 32'h1357_9BDF;
    beat(1'b1, A_SUM, 32'h0);
    beat(1'b1, A_CTRL, 32'h1);
    for (int i = 0; i < 40; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      beat(i[0], 16'h4000 + 16'(i * 4), (i % 5 == 0) ? 32'hFFFF_FFFF : x);
    end
    beat(1'b1, 16'h4800, 32'hFFFE_FFFE);
    beat(1'b1, 16'h4804, 32'h0003_0003);
    idle(4);
    rd(A_STAT, v); check("R7 not ready on 5th edge", {15'b0, v[16]}, 16'h0);
    rd(A_STAT, v); check("R10 back-to-back checksum ready", v, exp_stat(1'b1));
    rd(A_SUM, v);  check("R10 back-to-back partial", v, {m_hi, m_lo});
    beat(1'b1, A_CTRL, 32'h0);
  endtask

  task automatic t_preload;
    logic [31:0] v;
    beat(1'b1, A_SUM, 32'h0);
    beat(1'b1, A_CTRL, 32'h1);
    beat(1'b1, 16'h7FFC, 32'hABCD_1234);
    idle(6);
    rd(A_SUM, v); check("R8 preload value", v, 32'hABCD_1234);
    beat(1'b0, 16'h5000, 32'h0101_F0F0);
    beat(1'b1, A_CTRL, 32'h0);
    idle(6);
    rd(A_STAT, v); check("R8 checksum after preload", v, exp_stat(1'b1));
  endtask

  task automatic t_clear_mid;
    logic [31:0] v;
    beat(1'b1, A_CTRL, 32'h1);
    beat(1'b1, 16'h6000, 32'hFFFF_FFFF);
    beat(1'b1, 16'h6004, 32'h0001_0001);
    beat(1'b1, A_SUM, 32'hDEAD_BEEF);
    rd(A_STAT, v); check("R2 status right after clear", v, 32'h0001_FFFF);
    idle(8);
    rd(A_SUM, v); check("R2 cleared with carries dropped", v, 32'h0);
    beat(1'b1, A_CTRL, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ctrl();
    t_basic();
    t_disabled();
    t_own();
    t_burst();
    t_preload();
    t_clear_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule